// File: doc/BRIEF.md
# Counter-Addressed LIFO Stack

This block is a last-in first-out stack for a datapath that needs to park words and get them back in reverse order. The storage is one single-port synchronous RAM. A single up/down address counter is the stack pointer. The counter always holds the index of the next free slot.

A push writes the incoming word at the slot the counter names, and the counter then moves up by one. A pop first moves the counter down by one and then reads the RAM at the new value. The read is synchronous, so the popped word appears one clock after the pop strobe, and a valid strobe marks that cycle.

The empty and full flags are decoded from the counter. Full means the counter is all ones, so one RAM word is never used. Requests that cannot be served are dropped, and so is a push that arrives together with a pop.

Top module: `lifo_stack`

## Requirements
- R1: While `rst_n` is low the counter is zero. After reset `empty_o` is 1, `full_o` is 0 and `rd_valid_o` is 0.
- R2: An accepted push stores `wr_data_i` at the current counter value, then increments the counter. After one push into an empty stack, `empty_o` is 0.
- R3: An accepted pop decrements the counter, then reads the RAM at the new value. The word appears on `rd_data_o` with `rd_valid_o` high in the cycle after the pop strobe. Words come back in reverse order of pushing.
- R4: `empty_o` is 1 exactly when the counter is zero.
- R5: `full_o` is 1 exactly when the counter is all ones, so the stack holds 2^ADDR_W - 1 words.
- R6: A push while `full_o` is 1 is ignored. The counter stays the same and no stored word is overwritten.
- R7: A pop while `empty_o` is 1 is ignored. `rd_valid_o` stays 0 and the stack stays empty.
- R8: When push and pop are both high, the pop is served if the stack is not empty and the push is dropped. If the stack is empty, nothing changes.
- R9: `rd_data_o` holds the last popped word until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Last popped word |
| rd_valid_o | output | 1 | High in the cycle after an accepted pop |
| empty_o | output | 1 | Stack holds no words |
| full_o | output | 1 | Stack holds 2^ADDR_W - 1 words |

## Verification
The assertions check the local rules on every cycle:
- the counter moves by exactly one on each accepted operation;
- the RAM never writes and reads in the same cycle;
- the two flags are never high together;
- a rejected push or pop leaves the flags and the valid strobe untouched;
- a pop that coincides with a push still returns data.

Only the bench scenarios can show the rest. These are the reverse-order return of data, and the survival of stored words across an ignored push at full. They also cover the exact capacity of 2^ADDR_W - 1 words and the holding of the read word across idle cycles. The bench compares every popped word against a reference stack.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  // Operation selected for one cycle after arbitration
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } lifo_op_e;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
(
  input  logic     push_i,
  input  logic     pop_i,
  input  logic     empty_i,
  input  logic     full_i,
  output lifo_op_e op_o
);

  // Pop has priority; a push that meets a pop is dropped.
  always_comb begin
    op_o = OP_IDLE;
    if (pop_i) begin
      if (!empty_i) op_o = OP_POP;
    end else if (push_i) begin
      if (!full_i) op_o = OP_PUSH;
    end
  end

endmodule

// File: rtl/lifo_addr_cnt.sv
module lifo_addr_cnt #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              empty_o,
  output logic              full_o
);

  localparam logic [ADDR_W-1:0] CNT_ZERO = '0;
  localparam logic [ADDR_W-1:0] CNT_TOP  = '1;

  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = inc_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i)      cnt_d = cnt_q + 1'b1;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == CNT_ZERO);
  assign full_o  = (cnt_q == CNT_TOP);

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lifo_spram.sv
module lifo_spram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;

  assert_single_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_i, re_i}));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_q));

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              empty_o,
  output logic              full_o
);

  lifo_op_e          op;
  logic              do_push, do_pop;
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] ram_addr;
  logic              rvalid_q, rvalid_d;

  lifo_ctrl u_ctrl (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .empty_i (empty_o),
    .full_i  (full_o),
    .op_o    (op)
  );

  assign do_push = (op == OP_PUSH);
  assign do_pop  = (op == OP_POP);

  lifo_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (do_push),
    .dec_i   (do_pop),
    .cnt_o   (cnt),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  // Push addresses the current slot; pop addresses the slot below it.
  always_comb begin
    ram_addr = cnt;
    if (do_pop) ram_addr = cnt - 1'b1;
  end

  lifo_spram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (ram_addr),
    .we_i    (do_push),
    .re_i    (do_pop),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o)
  );

  assign rvalid_d = do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

  assign rd_valid_o = rvalid_q;

  assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> full_o);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i) |=> (empty_o && !rd_valid_o));

  assert_pop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o) |=> (rd_valid_o && !full_o));

  assert_pop_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> rd_valid_o);

endmodule

// File: tb/lifo_stack_bench.sv
module lifo_stack_bench;

  localparam int  DATA_W   = 8;
  localparam int  ADDR_W   = 4;
  localparam int  CAP      = (1 << ADDR_W) - 1;
  localparam time CLK_PER  = 10ns;

  typedef struct {
    logic [DATA_W-1:0] d;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              push_i, pop_i;
  logic [DATA_W-1:0] wr_data_i;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_valid_o, empty_o, full_o;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] model [$];
  exp_t              expq  [$];

  always #(CLK_PER/2) clk = ~clk;

  lifo_stack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lifo_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .empty_o    (empty_o),
    .full_o     (full_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares every valid read word against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected rd_valid", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rd_data_o == e.d, e.tag, int'(rd_data_o), int'(e.d));
      end
    end
  end

  // Driver: checks the flags against the model, then drives one cycle.
  task automatic step(input bit psh, input bit pp, input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    check(empty_o == (model.size() == 0), "R4 empty flag", int'(empty_o), int'(model.size() == 0));
    check(full_o == (model.size() == CAP), "R5 full flag", int'(full_o), int'(model.size() == CAP));
    push_i    = psh;
    pop_i     = pp;
    wr_data_i = d;
    if (pp) begin
      if (model.size() > 0) begin
        exp_t e;
        e.d   = model.pop_back();
        e.tag = tag;
        expq.push_back(e);
      end
    end else if (psh) begin
      if (model.size() < CAP) model.push_back(d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, "idle");
  endtask

  initial begin
    #(CLK_PER * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(empty_o == 1'b1, "R1 empty after reset", int'(empty_o), 1);
    check(full_o == 1'b0, "R1 full after reset", int'(full_o), 0);
    check(rd_valid_o == 1'b0, "R1 valid after reset", int'(rd_valid_o), 0);
    rst_n = 1'b1;

    // R2 R3 short push then pop, reverse order
    step(1, 0, 8'h11, "R2");
    step(0, 0, 8'h00, "R2");
    check(empty_o == 1'b0, "R2 not empty after push", int'(empty_o), 0);
    step(1, 0, 8'h22, "R2");
    step(1, 0, 8'h33, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, '0, "R3 lifo order");
    idle(2);

    // R7 pop on empty
    step(0, 1, '0, "R7");
    step(0, 0, '0, "R7");
    check(rd_valid_o == 1'b0, "R7 no valid on empty pop", int'(rd_valid_o), 0);
    check(empty_o == 1'b1, "R7 stays empty", int'(empty_o), 1);

    // R5 fill to capacity, R6 extra pushes ignored
    for (int i = 0; i < CAP; i++) step(1, 0, DATA_W'(8'hA0 + i), "R5");
    step(1, 0, 8'hEE, "R6");
    step(1, 0, 8'hEF, "R6");
    step(0, 0, '0, "R6");
    check(full_o == 1'b1, "R6 full held", int'(full_o), 1);
    for (int i = 0; i < CAP; i++) step(0, 1, '0, "R6 data intact");
    idle(2);

    // R8 simultaneous push and pop
    step(1, 1, 8'h55, "R8 empty both");
    step(1, 0, 8'h66, "R8");
    step(1, 0, 8'h77, "R8");
    step(1, 1, 8'h99, "R8 pop wins");
    step(0, 1, '0, "R8 remaining");
    idle(2);

    // interleaved pattern
    step(1, 0, 8'h01, "R3");
    step(0, 1, '0, "R3 interleave");
    step(1, 0, 8'h02, "R3");
    step(1, 0, 8'h03, "R3");
    step(0, 1, '0, "R3 interleave");
    step(1, 0, 8'h04, "R3");
    step(0, 1, '0, "R3 interleave");
    step(0, 1, '0, "R3 interleave");
    idle(2);

    // R9 hold after the last pop
    held = rd_data_o;
    idle(3);
    check(rd_data_o == held, "R9 rd_data held", int'(rd_data_o), int'(held));
    step(1, 0, 8'hC4, "R9");
    idle(1);
    check(rd_data_o == held, "R9 held across push", int'(rd_data_o), int'(held));
    step(0, 1, '0, "R9 pop");
    idle(2);

    check(expq.size() == 0, "R3 all pops returned", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule